// File: doc/BRIEF.md
# Burst-Mode Oscillator Frequency Tuning Loop

This block is the digital control loop of a duty-cycled all-digital PLL. It runs on the reference clock. It switches the oscillator and its tuning DACs on for a single reference cycle out of every `PERIOD` cycles, and counts the oscillator's rising edges during that window. In the cycle after the window it compares the count with the programmed frequency control word (`fcw`, the wanted output frequency divided by the reference frequency). The two tuning codes it holds are updated at that point and then kept until the next window.

The coarse code (7 bits) is a saturating accumulator of the count error. A count equal to `fcw` or `fcw+1` counts as zero coarse error. While the coarse error is zero, a fine loop trims a 9-bit fine code in bang-bang fashion. A count of exactly `fcw` means the extra edge did not arrive in time, so the fine code is raised. A count of `fcw+1` means it arrived early, so the fine code is lowered. The fine step is large while decisions keep going the same way, and drops to one LSB once they start alternating. A lock flag reports a run of zero-error bursts whose length software can program.

Top module: `burst_tune_loop`

## Requirements
- R1: `oscEn` and `dacEn` are high together for exactly one reference cycle, and bursts are spaced exactly `PERIOD` (default 10) cycles apart. Both are low in every other cycle.
- R2: The edge count is the number of oscillator rising edges while `oscEn` is high. It saturates at 255 (`CNT_W`=8), and the error is that count minus `fcw`.
- R3: When the error is neither 0 nor 1, the coarse code becomes the old code minus the error. The new code appears two reference cycles after the burst cycle, so it is used by the next burst.
- R4: A count of `fcw` or `fcw+1` leaves the coarse code unchanged.
- R5: While the error is neither 0 nor 1, the fine code does not change and the fine step returns to the large size.
- R6: With error 0 the fine code steps up. With error 1 it steps down.
- R7: The fine step is `FINE_BIG` (16) until two alternations in a row occur, counting the decision that makes the second one. After that the step is 1. It goes back to 16 once four same-direction decisions in a row have been made, counting the first of them.
- R8: The coarse code saturates at 0 and 127, and the fine code saturates at 0 and 511. Neither code wraps.
- R9: The codes change only in the cycle that follows evaluation. They are held at all other times.
- R10: Synchronous reset sets the coarse code to 64 and the fine code to 256, clears `oscEn`, `dacEn` and `coarseLock`, and restarts the burst phase.
- R11: `coarseLock` is high after the last `lockBursts` evaluations in a row have had zero coarse error. A nonzero error clears it at the next update. The run counter saturates at 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| oscClk | input | 1 | Oscillator output, counted during the burst |
| fcw | input | 8 | Expected edge count per burst |
| lockBursts | input | 4 | Zero-error bursts needed for coarse lock |
| oscEn | output | 1 | Oscillator enable, one cycle per period |
| dacEn | output | 1 | Tuning DAC enable, low outside the burst |
| coarseCode | output | 7 | Coarse tuning code |
| fineCode | output | 9 | Fine tuning code |
| coarseLock | output | 1 | Coarse loop locked |

## Verification
The bench drives the design with an oscillator model whose edge count follows the codes, and with forced counts. This brings out the corner cases. The first is the two-count zero window: if it were treated as a single value, the coarse code would creep after lock. The second is the switch from large to unit step after alternation: if it were wrong, the fine code would dither by 16 forever or never leave unit step. The other cases are saturation of both codes and of the edge count at their rails, where wrapping would throw the oscillator to the far end of its range, and the update landing one burst late, where an off-by-one would move the codes during the burst that measures them. A sweep over many control words compares every code, and the lock flag, with an arithmetic model after every burst.

// File: rtl/btl_pkg.sv
package btl_pkg;
  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic burst;  // oscillator and DAC window
    logic eval;   // compare count, update codes
    logic clr;    // clear the edge counter
  } strobe_t;
endpackage

// File: rtl/btl_ctrl.sv
module btl_ctrl #(
  parameter int PERIOD = 10
) (
  input  logic clk,
  input  logic rst,
  output btl_pkg::strobe_t stb
);
  localparam int PH_W = $clog2(PERIOD);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(PERIOD - 1);
  localparam logic [PH_W-1:0] CLR_PH = PH_W'(PERIOD / 2);

  logic [PH_W-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      stb <= '0;
    end else begin
      phase <= (phase == LAST_PH) ? '0 : phase + 1'b1;
      stb.burst <= (phase == LAST_PH);
      stb.eval <= stb.burst;
      stb.clr <= (phase == CLR_PH);
    end
  end
endmodule

// File: rtl/btl_edge_count.sv
module btl_edge_count #(
  parameter int CNT_W = 8
) (
  input  logic oscClk,
  input  logic clr,
  input  logic gate,
  output logic [CNT_W-1:0] count
);
  // clear comes from the reference domain during idle time; the count is
  // read there only after the oscillator has stopped
  always_ff @(posedge oscClk or posedge clr) begin
    if (clr) count <= '0;
    else if (gate && !(&count)) count <= count + 1'b1;
  end
endmodule

// File: rtl/btl_datapath.sv
module btl_datapath #(
  parameter int CNT_W = 8,
  parameter int LOCK_W = 4,
  parameter int COARSE_W = 7,
  parameter int FINE_W = 9,
  parameter int FINE_BIG = 16,
  parameter int BIG_RUN = 4
) (
  input  logic clk,
  input  logic rst,
  input  btl_pkg::strobe_t stb,
  input  logic [CNT_W-1:0] edgeCnt,
  input  logic [CNT_W-1:0] fcw,
  input  logic [LOCK_W-1:0] lockBursts,
  output logic [COARSE_W-1:0] coarseCode,
  output logic [FINE_W-1:0] fineCode,
  output logic coarseLock
);
  localparam int ERR_W = CNT_W + 1;
  localparam int SUM_W = ERR_W + COARSE_W;
  localparam int RUN_W = $clog2(BIG_RUN + 1);
  localparam logic [COARSE_W-1:0] COARSE_MID = COARSE_W'(1) << (COARSE_W - 1);
  localparam logic [FINE_W-1:0] FINE_MID = FINE_W'(1) << (FINE_W - 1);

  logic [ERR_W-1:0] errVal;
  logic dirUp, oneOver, inWindow;
  logic [SUM_W-1:0] coarseSum;
  logic [COARSE_W-1:0] coarseSat;
  logic [FINE_W:0] stepVal, fineUpSum;
  logic [FINE_W-1:0] fineNext;
  logic bigMode, prevValid, prevUp, alternating, bigNext;
  logic [1:0] altCnt, altNext;
  logic [RUN_W-1:0] runCnt, runNext;
  logic [LOCK_W-1:0] lockRun, lockNext;

  // frequency error and zero window
  always_comb begin
    errVal = {1'b0, edgeCnt} - {1'b0, fcw};
    dirUp = (edgeCnt == fcw);
    oneOver = ({1'b0, edgeCnt} == ({1'b0, fcw} + 1'b1));
    inWindow = dirUp || oneOver;
  end

  // coarse accumulator with saturation
  always_comb begin
    coarseSum = {{(SUM_W-COARSE_W){1'b0}}, coarseCode}
              - {{(SUM_W-ERR_W){errVal[ERR_W-1]}}, errVal};
    if (coarseSum[SUM_W-1]) coarseSat = '0;
    else if (|coarseSum[SUM_W-2:COARSE_W]) coarseSat = '1;
    else coarseSat = coarseSum[COARSE_W-1:0];
  end

  // bang-bang fine step with adaptive size
  always_comb begin
    stepVal = bigMode ? (FINE_W+1)'(FINE_BIG) : (FINE_W+1)'(1);
    fineUpSum = {1'b0, fineCode} + stepVal;
    if (dirUp) fineNext = fineUpSum[FINE_W] ? '1 : fineUpSum[FINE_W-1:0];
    else if ({1'b0, fineCode} < stepVal) fineNext = '0;
    else fineNext = fineCode - stepVal[FINE_W-1:0];

    alternating = prevValid && (dirUp != prevUp);
    if (!alternating) altNext = 2'd0;
    else if (altCnt == 2'd2) altNext = 2'd2;
    else altNext = altCnt + 2'd1;
    if (prevValid && !alternating)
      runNext = (&runCnt) ? runCnt : runCnt + 1'b1;
    else
      runNext = RUN_W'(1);
    bigNext = bigMode ? (altNext != 2'd2) : (runNext >= RUN_W'(BIG_RUN));
  end

  always_comb begin
    if (!inWindow) lockNext = '0;
    else lockNext = (&lockRun) ? lockRun : lockRun + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      coarseCode <= COARSE_MID;
      fineCode <= FINE_MID;
      bigMode <= 1'b1;
      prevValid <= 1'b0;
      prevUp <= 1'b0;
      altCnt <= '0;
      runCnt <= '0;
      lockRun <= '0;
      coarseLock <= 1'b0;
    end else if (stb.eval) begin
      lockRun <= lockNext;
      coarseLock <= (lockNext >= lockBursts);
      if (!inWindow) begin
        coarseCode <= coarseSat;
        bigMode <= 1'b1;
        prevValid <= 1'b0;
        altCnt <= '0;
        runCnt <= '0;
      end else begin
        fineCode <= fineNext;
        bigMode <= bigNext;
        prevValid <= 1'b1;
        prevUp <= dirUp;
        altCnt <= altNext;
        runCnt <= runNext;
      end
    end
  end
endmodule

// File: rtl/burst_tune_loop.sv
module burst_tune_loop #(
  parameter int PERIOD = 10,
  parameter int CNT_W = 8,
  parameter int LOCK_W = 4,
  parameter int COARSE_W = 7,
  parameter int FINE_W = 9,
  parameter int FINE_BIG = 16,
  parameter int BIG_RUN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic oscClk,
  input  logic [CNT_W-1:0] fcw,
  input  logic [LOCK_W-1:0] lockBursts,
  output logic oscEn,
  output logic dacEn,
  output logic [COARSE_W-1:0] coarseCode,
  output logic [FINE_W-1:0] fineCode,
  output logic coarseLock
);
  btl_pkg::strobe_t stb;
  logic [CNT_W-1:0] edgeCnt;

  btl_ctrl #(.PERIOD(PERIOD)) u_ctrl (.clk(clk), .rst(rst), .stb(stb));

  btl_edge_count #(.CNT_W(CNT_W)) u_cnt (
    .oscClk(oscClk), .clr(stb.clr), .gate(stb.burst), .count(edgeCnt));

  btl_datapath #(
    .CNT_W(CNT_W), .LOCK_W(LOCK_W), .COARSE_W(COARSE_W), .FINE_W(FINE_W),
    .FINE_BIG(FINE_BIG), .BIG_RUN(BIG_RUN)
  ) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .edgeCnt(edgeCnt), .fcw(fcw),
    .lockBursts(lockBursts), .coarseCode(coarseCode), .fineCode(fineCode),
    .coarseLock(coarseLock));

  assign oscEn = stb.burst;
  assign dacEn = stb.burst;
endmodule

// File: rtl/burst_tune_loop_chk.sv
module burst_tune_loop_chk #(
  parameter int CNT_W = 8,
  parameter int COARSE_W = 7,
  parameter int FINE_W = 9
) (
  input logic clk,
  input logic rst,
  input logic oscEn,
  input logic evalStb,
  input logic [CNT_W-1:0] edgeCnt,
  input logic [CNT_W-1:0] fcw,
  input logic [COARSE_W-1:0] coarseCode,
  input logic [FINE_W-1:0] fineCode,
  input logic coarseLock
);
  logic inWin;
  assign inWin = ({1'b0, edgeCnt} == {1'b0, fcw}) ||
                 ({1'b0, edgeCnt} == ({1'b0, fcw} + 1'b1));

  p_burst_single_r1: assert property (@(posedge clk) disable iff (rst)
    oscEn |=> !oscEn);
  p_eval_after_burst_r3: assert property (@(posedge clk) disable iff (rst)
    (evalStb && !$past(rst)) |-> $past(oscEn));
  p_window_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (evalStb && inWin) |=> $stable(coarseCode));
  p_fine_frozen_r5: assert property (@(posedge clk) disable iff (rst)
    (evalStb && !inWin) |=> $stable(fineCode));
  p_codes_held_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(evalStb) && !$past(rst)) |-> ($stable(coarseCode) && $stable(fineCode)));
  p_lock_drop_r11: assert property (@(posedge clk) disable iff (rst)
    (evalStb && !inWin) |=> !coarseLock);
endmodule

bind burst_tune_loop burst_tune_loop_chk #(
  .CNT_W(CNT_W), .COARSE_W(COARSE_W), .FINE_W(FINE_W)
) u_chk (
  .clk(clk), .rst(rst), .oscEn(oscEn), .evalStb(stb.eval), .edgeCnt(edgeCnt),
  .fcw(fcw), .coarseCode(coarseCode), .fineCode(fineCode),
  .coarseLock(coarseLock));

// File: tb/sim_burst_tune_loop.sv
`timescale 1ns/10ps
module sim_burst_tune_loop;
  localparam int CLK_PERIOD = 100;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic oscClk = 1'b0;
  logic [7:0] fcw = 8'd50;
  logic [3:0] lockBursts = 4'd3;
  logic oscEn, dacEn, coarseLock;
  logic [6:0] coarseCode;
  logic [8:0] fineCode;

  int nChecks = 0;
  int nFail = 0;
  int forceN = -1;
  int burstN = 0;
  bit done = 0;

  burst_tune_loop u0 (
    .clk(clk), .rst(rst), .oscClk(oscClk), .fcw(fcw), .lockBursts(lockBursts),
    .oscEn(oscEn), .dacEn(dacEn), .coarseCode(coarseCode), .fineCode(fineCode),
    .coarseLock(coarseLock));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // oscillator model: edges per burst follow the codes unless forced
  always begin
    @(posedge oscEn);
    #1;
    burstN = (forceN >= 0) ? forceN : int'(coarseCode) + int'(fineCode) / 128;
    for (int i = 0; i < burstN; i++) begin
      oscClk = 1'b1; #0.1;
      oscClk = 1'b0; #0.1;
    end
  end

  // reference model of the loop, checked after every burst
  int mC, mF, mAlt, mRun, mLockRun, stN1, stN2, sinceBurst, cnt, err, step;
  bit mBig, mPrevV, mPrevUp, mLock, st1, st2, seenBurst, up, altn;
  logic [6:0] lastC;
  logic [8:0] lastF;

  always @(negedge clk) begin
    if (rst) begin
      mC = 64; mF = 256; mBig = 1; mPrevV = 0; mAlt = 0; mRun = 0;
      mLockRun = 0; mLock = 0; st1 = 0; st2 = 0; seenBurst = 0; sinceBurst = 0;
      lastC = coarseCode; lastF = fineCode;
    end else begin
      chk(oscEn == dacEn, "R1 dac enable", int'(dacEn), int'(oscEn));
      sinceBurst++;
      if (oscEn) begin
        if (seenBurst) chk(sinceBurst == PERIOD, "R1 burst spacing", sinceBurst, PERIOD);
        seenBurst = 1;
        sinceBurst = 0;
      end
      if (!st2) begin
        chk(coarseCode == lastC, "R9 coarse held", int'(coarseCode), int'(lastC));
        chk(fineCode == lastF, "R9 fine held", int'(fineCode), int'(lastF));
      end else begin
        cnt = (stN2 > 255) ? 255 : stN2;
        err = cnt - int'(fcw);
        if (!(err == 0 || err == 1)) begin
          mC = mC - err;
          if (mC < 0) mC = 0;
          if (mC > 127) mC = 127;
          mBig = 1; mPrevV = 0; mAlt = 0; mRun = 0; mLockRun = 0;
          chk(coarseCode == mC, (stN2 > 255) ? "R2 count saturation" :
              ((mC == 0 || mC == 127) ? "R8 coarse rail" : "R3 coarse update"),
              int'(coarseCode), mC);
          chk(fineCode == mF, "R5 fine frozen", int'(fineCode), mF);
        end else begin
          up = (err == 0);
          step = mBig ? 16 : 1;
          altn = mPrevV && (up != mPrevUp);
          mF = up ? mF + step : mF - step;
          if (mF > 511) mF = 511;
          if (mF < 0) mF = 0;
          mAlt = altn ? ((mAlt >= 2) ? 2 : mAlt + 1) : 0;
          mRun = (mPrevV && !altn) ? mRun + 1 : 1;
          mBig = mBig ? (mAlt != 2) : (mRun >= 4);
          mPrevV = 1; mPrevUp = up;
          mLockRun = (mLockRun < 15) ? mLockRun + 1 : 15;
          chk(coarseCode == mC, "R4 window hold", int'(coarseCode), mC);
          chk(fineCode == mF, (mF == 0 || mF == 511) ? "R8 fine rail" :
              "R6 R7 fine step", int'(fineCode), mF);
        end
        mLock = (mLockRun >= int'(lockBursts));
        chk(coarseLock == mLock, "R11 lock", int'(coarseLock), int'(mLock));
      end
      lastC = coarseCode; lastF = fineCode;
      st2 = st1; stN2 = stN1;
      st1 = oscEn; stN1 = burstN;
    end
  end

  task automatic startCase(input int f, input int l, input int force_n);
    @(posedge clk); #(CLK_PERIOD/4);
    rst = 1'b1; fcw = 8'(f); lockBursts = 4'(l); forceN = force_n;
    repeat (2) @(posedge clk);
    #(CLK_PERIOD/4);
    rst = 1'b0;
  endtask

  task automatic runBursts(input int b);
    repeat (b * PERIOD) @(posedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(coarseCode == 7'd64, "R10 coarse reset", int'(coarseCode), 64);
    chk(fineCode == 9'd256, "R10 fine reset", int'(fineCode), 256);
    chk(!oscEn && !dacEn, "R10 enables off", int'(oscEn), 0);
    chk(!coarseLock, "R10 lock off", int'(coarseLock), 0);
    @(posedge clk); #(CLK_PERIOD/4);
    rst = 1'b0;
    runBursts(22);           // acquisition, step drop to unit
    forceN = 50; runBursts(8);  // same direction run: back to large step
    forceN = 51; runBursts(6);
    startCase(0, 3, -1); runBursts(6);     // coarse low rail
    startCase(200, 3, -1); runBursts(6);   // coarse high rail
    startCase(80, 2, 80); runBursts(22);   // fine high rail
    startCase(80, 2, 81); runBursts(22);   // fine low rail
    startCase(250, 3, 300); runBursts(3);  // edge count saturation
    for (int f = 10; f <= 130; f += 8) begin
      startCase(f, 2, -1);
      runBursts(14);
    end
    finishRun();
  end

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end
endmodule